// File: doc/BRIEF.md
# Interrupt Moderation Delay Timer Pair

This block holds two countdown timers that hold back a completion interrupt for one traffic direction. Each time a descriptor completes, the per-packet timer starts again from its full delay, so a steady stream of completions keeps pushing the interrupt later. The absolute timer is started only by the first completion that finds it idle, so it puts a hard limit on how long an interrupt can be held back. Whichever timer runs out first raises a one-cycle cause request and stops both timers.

Both delays are counted in units of a shared timer tick. The tick is `TICK_CYCLES` clock cycles long and comes from a free-running prescaler. When a completion arrives and both delays are zero, no timer starts. The block instead raises an immediate-post request. A cancel strobe from the interrupt controller clears both timers at once.

One parameter, `IS_TX`, selects the arming rules. In receive mode every completion arms the timers. In transmit mode a completion arms them only when its interrupt-delay-enable flag is set. In transmit mode the absolute timer also starts only when both delays are nonzero.

Top module: `intr_delay_pair`

## Requirements
- R1: After reset, `cause_req`, `post_now`, `pkt_pending` and `abs_pending` are all low.
- R2: A completion that arms the timers with a nonzero packet delay P loads the packet timer with P, even if it is already running. With `TICK_CYCLES`=1 and no other event, `cause_req` goes high P clock edges after the edge that sampled the last completion.
- R3: In receive mode, a completion with a nonzero absolute delay A starts the absolute timer only if it is idle. A countdown already in progress is never restarted, so it expires A ticks after the completion that started it.
- R4: When either timer reaches zero, `cause_req` is high for exactly one cycle. In that same cycle `pkt_pending` and `abs_pending` are both low.
- R5: A completion that arms the timers while both delays are zero raises `post_now` for one cycle, in the cycle right after the sampling edge. It starts no timer and causes no `cause_req`.
- R6: In receive mode the `ide` input has no effect. Completions arm the timers whether `ide` is 0 or 1.
- R7: In transmit mode, a completion with `ide`=0 starts no timer and raises neither `post_now` nor `cause_req`.
- R8: In transmit mode, the absolute timer starts only if both delays are nonzero. With a zero packet delay and a nonzero absolute delay, nothing is armed.
- R9: `cancel` clears both timers and their pending flags. No `cause_req` follows. `cancel` takes priority over a completion sampled at the same edge, so that completion arms nothing and posts nothing.
- R10: The delays count ticks of `TICK_CYCLES` clocks. A timer loaded with D expires between (D-1)*TICK_CYCLES+1 and D*TICK_CYCLES clock edges after the loading edge.
- R11: The delay inputs are sampled only at an arming completion. Changing `abs_delay` while the absolute timer runs does not change when it expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_delay | input | DELAY_W | Per-packet delay, in ticks |
| abs_delay | input | DELAY_W | Absolute delay, in ticks |
| done | input | 1 | Completion strobe, one cycle |
| ide | input | 1 | Interrupt-delay-enable flag of the completion (used only when IS_TX=1) |
| cancel | input | 1 | Clears both timers |
| cause_req | output | 1 | One-cycle request to post the timer cause |
| pkt_pending | output | 1 | Packet timer is running |
| abs_pending | output | 1 | Absolute timer is running |
| post_now | output | 1 | One-cycle request to post immediately (both delays zero) |

## Verification
The bench builds three copies of the block, all driven by the same inputs. A receive-mode copy and a transmit-mode copy both use `TICK_CYCLES`=1, so every expiry lands on an exact clock edge. That lets the bench check exact latencies, the packet timer's reload and the absolute timer's no-restart rule. The third copy is in receive mode with `TICK_CYCLES`=4. Because its prescaler phase is arbitrary, the bench checks its expiry against the window that tick scaling allows. Running one vector table through both mode copies shows the receive and transmit arming rules side by side for the same delay pairs.

// File: rtl/intr_delay_pair.sv
module intr_delay_pair #(
  parameter bit IS_TX       = 1'b0,
  parameter int DELAY_W     = 16,
  parameter int TICK_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DELAY_W-1:0] pkt_delay,
  input  logic [DELAY_W-1:0] abs_delay,
  input  logic               done,
  input  logic               ide,
  input  logic               cancel,
  output logic               cause_req,
  output logic               pkt_pending,
  output logic               abs_pending,
  output logic               post_now
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic               tick;
  logic [DELAY_W-1:0] pkt_cnt, abs_cnt;

  generate
    if (TICK_CYCLES > 1) begin : g_pre
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n)                            pre <= '0;
        else if (pre == PW'(TICK_CYCLES - 1))  pre <= '0;
        else                                   pre <= pre + PW'(1);
      end
      assign tick = (pre == PW'(TICK_CYCLES - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  wire arm      = IS_TX ? (done & ide) : done;
  wire p_nz     = |pkt_delay;
  wire a_nz     = |abs_delay;
  wire pkt_load = arm & p_nz;
  wire abs_load = arm & a_nz & (abs_cnt == '0) & (IS_TX ? p_nz : 1'b1);
  wire zero_arm = arm & ~p_nz & ~a_nz;
  wire fire     = tick & ((pkt_cnt == ONE) | (abs_cnt == ONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_cnt   <= '0;
      abs_cnt   <= '0;
      cause_req <= 1'b0;
      post_now  <= 1'b0;
    end else begin
      post_now <= zero_arm & ~cancel;
      if (cancel) begin
        pkt_cnt   <= '0;
        abs_cnt   <= '0;
        cause_req <= 1'b0;
      end else if (fire) begin
        pkt_cnt   <= '0;
        abs_cnt   <= '0;
        cause_req <= 1'b1;
      end else begin
        cause_req <= 1'b0;
        if (pkt_load)                     pkt_cnt <= pkt_delay;
        else if (tick && pkt_cnt != '0)   pkt_cnt <= pkt_cnt - ONE;
        if (abs_load)                     abs_cnt <= abs_delay;
        else if (tick && abs_cnt != '0)   abs_cnt <= abs_cnt - ONE;
      end
    end
  end

  assign pkt_pending = (pkt_cnt != '0);
  assign abs_pending = (abs_cnt != '0);

  // R4
  expiry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_req |-> (!pkt_pending && !abs_pending));

  // R9
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!pkt_pending && !abs_pending && !cause_req && !post_now));

  // R3
  abs_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abs_pending |=> (abs_cnt <= $past(abs_cnt)));

  // R5
  post_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_now |-> $past(done));

  // R4
  cause_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_req |=> !cause_req);

endmodule

// File: tb/intr_delay_pair_bench.sv
`timescale 1ns/1ps
module intr_delay_pair_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pkt_delay = '0, abs_delay = '0;
  logic        done = 1'b0, ide = 1'b0, cancel = 1'b0;
  logic        rx_cause, rx_pp, rx_ap, rx_post;
  logic        tx_cause, tx_pp, tx_ap, tx_post;
  logic        sl_cause, sl_pp, sl_ap, sl_post;
  int          checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  intr_delay_pair #(.IS_TX(1'b0), .DELAY_W(16), .TICK_CYCLES(1)) u_intr_delay_pair (
    .clk(clk), .rst_n(rst_n), .pkt_delay(pkt_delay), .abs_delay(abs_delay),
    .done(done), .ide(ide), .cancel(cancel), .cause_req(rx_cause),
    .pkt_pending(rx_pp), .abs_pending(rx_ap), .post_now(rx_post));

  intr_delay_pair #(.IS_TX(1'b1), .DELAY_W(16), .TICK_CYCLES(1)) u_intr_delay_pair_tx (
    .clk(clk), .rst_n(rst_n), .pkt_delay(pkt_delay), .abs_delay(abs_delay),
    .done(done), .ide(ide), .cancel(cancel), .cause_req(tx_cause),
    .pkt_pending(tx_pp), .abs_pending(tx_ap), .post_now(tx_post));

  intr_delay_pair #(.IS_TX(1'b0), .DELAY_W(16), .TICK_CYCLES(4)) u_intr_delay_pair_slow (
    .clk(clk), .rst_n(rst_n), .pkt_delay(pkt_delay), .abs_delay(abs_delay),
    .done(done), .ide(ide), .cancel(cancel), .cause_req(sl_cause),
    .pkt_pending(sl_pp), .abs_pending(sl_ap), .post_now(sl_post));

  // {pkt[7:0], abs[7:0], ide, rx_lat[7:0], tx_lat[7:0], rx_post, tx_post}; lat 0 = none
  localparam logic [34:0] VEC [8] = '{
    {8'd3, 8'd0, 1'b1, 8'd3, 8'd3, 1'b0, 1'b0},
    {8'd0, 8'd4, 1'b1, 8'd4, 8'd0, 1'b0, 1'b0},
    {8'd5, 8'd2, 1'b1, 8'd2, 8'd2, 1'b0, 1'b0},
    {8'd2, 8'd6, 1'b1, 8'd2, 8'd2, 1'b0, 1'b0},
    {8'd0, 8'd0, 1'b1, 8'd0, 8'd0, 1'b1, 1'b1},
    {8'd3, 8'd0, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0},
    {8'd0, 8'd0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b0},
    {8'd1, 8'd1, 1'b1, 8'd1, 8'd1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_done();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic clear_all();
    cancel = 1'b1; step(); cancel = 1'b0; step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rxf, txf, rxpf, txpf, j;
    repeat (3) @(negedge clk);
    // R1
    chk(!rx_cause && !rx_pp && !rx_ap && !rx_post, "R1 rx reset outputs", rx_cause, 0);
    chk(!tx_cause && !tx_pp && !tx_ap && !tx_post, "R1 tx reset outputs", tx_cause, 0);
    chk(!sl_cause && !sl_pp && !sl_ap && !sl_post, "R1 slow reset outputs", sl_cause, 0);
    rst_n = 1'b1;
    step();

    // table: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      clear_all();
      pkt_delay = 16'(VEC[i][34:27]);
      abs_delay = 16'(VEC[i][26:19]);
      ide       = VEC[i][18];
      pulse_done();
      rxf = -1; txf = -1; rxpf = -1; txpf = -1;
      for (int k = 0; k <= 20; k++) begin
        if (rx_cause && rxf < 0) rxf = k;
        if (tx_cause && txf < 0) txf = k;
        if (rx_post && rxpf < 0) rxpf = k;
        if (tx_post && txpf < 0) txpf = k;
        if (k < 20) step();
      end
      chk(rxf == ((VEC[i][17:10] == 0) ? -1 : int'(VEC[i][17:10])),
          $sformatf("R2/R3/R6 rx latency vec%0d", i), rxf, int'(VEC[i][17:10]));
      chk(txf == ((VEC[i][9:2] == 0) ? -1 : int'(VEC[i][9:2])),
          $sformatf("R7/R8 tx latency vec%0d", i), txf, int'(VEC[i][9:2]));
      chk(rxpf == (VEC[i][1] ? 0 : -1), $sformatf("R5 rx post vec%0d", i), rxpf, VEC[i][1] ? 0 : -1);
      chk(txpf == (VEC[i][0] ? 0 : -1), $sformatf("R5/R7 tx post vec%0d", i), txpf, VEC[i][0] ? 0 : -1);
    end

    // R2 reload on second completion, R4 one-cycle pulse
    clear_all();
    pkt_delay = 16'd4; abs_delay = 16'd0; ide = 1'b1;
    pulse_done(); step(); step();
    chk(rx_pp && !rx_cause, "R2 packet timer still running", rx_pp, 1);
    pulse_done();
    j = -1;
    for (int k = 0; k <= 8; k++) begin
      if (rx_cause && j < 0) j = k;
      if (j >= 0) break;
      step();
    end
    chk(j == 4, "R2 reload latency", j, 4);
    chk(!rx_pp && !rx_ap, "R4 pendings low with cause", rx_pp, 0);
    step();
    chk(!rx_cause, "R4 cause lasts one cycle", rx_cause, 0);

    // R3 absolute not restarted, R11 new delay ignored
    clear_all();
    pkt_delay = 16'd0; abs_delay = 16'd5;
    pulse_done(); step();
    abs_delay = 16'd9;
    pulse_done();
    j = -1;
    for (int k = 0; k <= 12; k++) begin
      if (rx_cause && j < 0) j = k;
      if (j >= 0) break;
      step();
    end
    chk(j == 3, "R3/R11 absolute expiry from first completion", j, 3);

    // R9 cancel while running
    clear_all();
    pkt_delay = 16'd5; abs_delay = 16'd7;
    pulse_done(); step();
    chk(rx_pp && rx_ap, "R9 both running before cancel", rx_ap, 1);
    cancel = 1'b1; step(); cancel = 1'b0;
    chk(!rx_pp && !rx_ap && !tx_pp && !tx_ap, "R9 pendings cleared", rx_pp, 0);
    j = 0;
    for (int k = 0; k < 10; k++) begin
      if (rx_cause || tx_cause) j++;
      step();
    end
    chk(j == 0, "R9 no cause after cancel", j, 0);

    // R9 cancel beats completion in the same cycle
    pkt_delay = 16'd5; abs_delay = 16'd7;
    done = 1'b1; cancel = 1'b1; step(); done = 1'b0; cancel = 1'b0;
    chk(!rx_pp && !rx_ap, "R9 same-cycle cancel wins", rx_pp, 0);
    pkt_delay = 16'd0; abs_delay = 16'd0;
    done = 1'b1; cancel = 1'b1; step(); done = 1'b0; cancel = 1'b0;
    chk(!rx_post && !tx_post, "R9 same-cycle cancel blocks post", rx_post, 0);

    // R10 tick scaling on the slow copy
    clear_all();
    pkt_delay = 16'd3; abs_delay = 16'd0;
    pulse_done();
    j = -1;
    for (int k = 0; k <= 30; k++) begin
      if (sl_cause && j < 0) j = k;
      if (j >= 0) break;
      step();
    end
    chk(j >= 9 && j <= 12, "R10 slow expiry window", j, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule